// File: doc/BRIEF.md
# ADC sampling and conversion sequencer

This block is the digital control of an eight-channel, ten-bit serial converter. It decides when the sample-and-hold acquires, when a successive-approximation conversion runs, and whether a chip-select frame carries only a read-out. The analog comparator is replaced by the `cmp_in` port. That port is sampled once per system clock while a conversion is running. Every control input (chip select, start strobe, I/O clock and serial data) passes through a two-flop synchroniser into the system clock domain. Edge detection follows the synchronisers. All of the logic runs on `clk`.

There are two ways to start a sample. The first is through the start strobe while chip select is high. Sampling lasts as long as the strobe stays low, and its rising edge holds the sample and sets a sticky flag. The flag makes the next chip-select frame a read-only frame. The second is through a normal frame, which samples for a fixed six I/O clock periods once the channel address has been shifted in. In both cases the conversion starts two system clocks after the hold. It then resolves one bit per clock from the MSB down.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Out of reset, `sample_en` is 0, `eoc` is 1, `sdo` is 0 and `hold_ch` is 0.
- R2: A strobe falling edge seen while chip select is high starts sampling: `sample_en` goes to 1 and `hold_ch` takes the preset channel. `eoc` goes to 0 at the same time, which discards the waiting result.
- R3: When sampling ends, `sample_en` falls. `eoc` stays 0 and rises exactly 12 system clocks later: a 2-clock delay, then 10 bit clocks.
- R4: The result bit for position 9 is `cmp_in` as sampled at the third clock edge after the hold. Each later edge gives the next lower bit. The next frame shifts the result out on `sdo`, MSB first: bit 9 is valid from the chip-select fall, and each I/O clock falling edge advances one bit.
- R5: A frame that begins while the async flag is set is read-only. It shifts out the previous result and loads the address, but `sample_en` stays 0 and `eoc` stays 1.
- R6: A frame that begins with the flag clear samples. `sample_en` goes to 1 after the 4th I/O clock rising edge and to 0 after the 10th. `eoc` is 0 while sampling. A conversion follows, with the same timing as R3.
- R7: The first 4 `sdi` bits of a frame, taken on I/O clock rising edges MSB first, form the address. Its low 3 bits are the channel and bit 3 is ignored. That channel becomes the preset channel for later strobe sampling, and it is the `hold_ch` of the frame's own sampling.
- R8: The flag is cleared at every chip-select rising edge. After a strobe conversion, the first frame is read-only, the second frame samples, and so does the frame after that.
- R9: Strobe edges seen while chip select is low are ignored. They start no sampling and do not set the flag.
- R10: A strobe fall on the pin shows up as `sample_en` = 1 after the third `clk` rising edge following the change, because of the synchroniser and edge detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| start_n | input | 1 | Active-low start strobe, asynchronous |
| io_clk | input | 1 | Serial I/O clock, asynchronous, slower than clk |
| sdi | input | 1 | Serial address input |
| cmp_in | input | 1 | Comparator decision, one bit per clock during conversion |
| sdo | output | 1 | Serial result output |
| sample_en | output | 1 | Sample-and-hold acquiring |
| hold_ch | output | 3 | Channel being sampled or held |
| eoc | output | 1 | High when a result is loaded and ready |

## Verification
The assertions assume that a hold is never overtaken by a new strobe fall before its conversion has started. They also assume that a chip-select rise never cuts short a frame's sampling window. Under those conditions every fall of `sample_en` leads to a conversion two clocks later. The stimulus keeps to this: it waits for `eoc` to return after each conversion before the next strobe or frame. Every frame carries all ten I/O clock periods, and the I/O clock runs twenty system clocks per period. That slow clock also gives the synchronisers room to deliver each `sdi` bit before its rising edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int DEF_RES_W   = 10;
  localparam int DEF_ADDR_W  = 4;
  localparam int DEF_CH_W    = 3;
  localparam int DEF_SAMP_IO = 6;
  localparam int DEF_CONV_DLY = 2;
  localparam int DEF_SYNC    = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMP_EXT,
    ST_SAMP_FRM,
    ST_WAIT,
    ST_CONV
  } seq_state_e;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      q_prev <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      q_prev <= chain[STAGES-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_seq_frame.sv
module adc_seq_frame #(
  parameter int RES_W   = 10,
  parameter int ADDR_W  = 4,
  parameter int SAMP_IO = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_low,
  input  logic              io_rise,
  input  logic              io_fall,
  input  logic              sdi_s,
  input  logic [RES_W-1:0]  load_val,
  output logic              sdo,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_done,
  output logic              samp_end
);
  localparam int LAST   = ADDR_W + SAMP_IO;
  localparam int CNT_W  = $clog2(LAST + 1) + 1;

  logic [CNT_W-1:0]  rise_cnt;
  logic [ADDR_W-1:0] addr_sh;
  logic [RES_W-1:0]  out_sh;
  logic              rise_ok;

  function automatic logic [ADDR_W-1:0] shift_in(input logic [ADDR_W-1:0] v, input logic b);
    return {v[ADDR_W-2:0], b};
  endfunction

  assign rise_ok   = cs_low && io_rise && !cs_fall;
  assign addr      = shift_in(addr_sh, sdi_s);
  assign addr_done = rise_ok && (rise_cnt == CNT_W'(ADDR_W - 1));
  assign samp_end  = rise_ok && (rise_cnt == CNT_W'(LAST - 1));
  assign sdo       = out_sh[RES_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt <= '0;
      addr_sh  <= '0;
      out_sh   <= '0;
    end else if (cs_fall) begin
      rise_cnt <= '0;
      out_sh   <= load_val;
    end else if (cs_low) begin
      if (io_rise && rise_cnt != CNT_W'(LAST)) rise_cnt <= rise_cnt + 1'b1;
      if (io_rise && rise_cnt < CNT_W'(ADDR_W)) addr_sh <= addr;
      if (io_fall) out_sh <= {out_sh[RES_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int CH_W     = 3,
  parameter int CONV_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_fall,
  input  logic             start_rise,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             cs_high,
  input  logic             addr_done,
  input  logic [CH_W-1:0]  addr_ch,
  input  logic             samp_end,
  input  logic             cmp_in,
  output logic             sample_en,
  output logic [CH_W-1:0]  hold_ch,
  output logic             eoc,
  output logic [RES_W-1:0] result,
  output logic             frame_ro,
  output logic             async_flag,
  output logic             conv_busy
);
  localparam int IDX_W = $clog2(RES_W);
  localparam int DLY_W = $clog2(CONV_DLY + 1);

  seq_state_e       state;
  logic [DLY_W-1:0] dly_cnt;
  logic [IDX_W-1:0] bit_idx;
  logic [RES_W-1:0] sar;
  logic [CH_W-1:0]  preset_ch;
  logic             ext_go, ext_hold, frm_go, frm_hold, frm_abort;

  function automatic logic [RES_W-1:0] sar_put(input logic [RES_W-1:0] r,
                                               input logic [IDX_W-1:0] i,
                                               input logic b);
    logic [RES_W-1:0] t;
    t = r;
    t[i] = b;
    return t;
  endfunction

  assign ext_go    = start_fall && cs_high;
  assign ext_hold  = start_rise && (state == ST_SAMP_EXT);
  assign frm_go    = addr_done && !frame_ro && (state == ST_IDLE);
  assign frm_hold  = samp_end && (state == ST_SAMP_FRM);
  assign frm_abort = cs_rise && (state == ST_SAMP_FRM);

  assign sample_en = (state == ST_SAMP_EXT) || (state == ST_SAMP_FRM);
  assign conv_busy = (state == ST_CONV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      async_flag <= 1'b0;
      frame_ro   <= 1'b0;
      preset_ch  <= '0;
    end else begin
      if (ext_hold) async_flag <= 1'b1;
      else if (cs_rise) async_flag <= 1'b0;
      if (cs_fall) frame_ro <= async_flag;
      if (addr_done) preset_ch <= addr_ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      dly_cnt <= '0;
      bit_idx <= '0;
      sar     <= '0;
      result  <= '0;
      hold_ch <= '0;
      eoc     <= 1'b1;
    end else if (ext_go) begin
      state   <= ST_SAMP_EXT;
      hold_ch <= preset_ch;
      eoc     <= 1'b0;
      result  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (frm_go) begin
          state   <= ST_SAMP_FRM;
          hold_ch <= addr_ch;
          eoc     <= 1'b0;
        end
        ST_SAMP_EXT: if (ext_hold) begin
          state   <= ST_WAIT;
          dly_cnt <= '0;
        end
        ST_SAMP_FRM: begin
          if (frm_hold) begin
            state   <= ST_WAIT;
            dly_cnt <= '0;
          end else if (frm_abort) begin
            state <= ST_IDLE;
            eoc   <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (dly_cnt == DLY_W'(CONV_DLY - 1)) begin
            state   <= ST_CONV;
            bit_idx <= IDX_W'(RES_W - 1);
            sar     <= '0;
          end else begin
            dly_cnt <= dly_cnt + 1'b1;
          end
        end
        ST_CONV: begin
          sar <= sar_put(sar, bit_idx, cmp_in);
          if (bit_idx == '0) begin
            result <= sar_put(sar, bit_idx, cmp_in);
            eoc    <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            bit_idx <= bit_idx - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W    = DEF_RES_W,
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int CH_W     = DEF_CH_W,
  parameter int SAMP_IO  = DEF_SAMP_IO,
  parameter int CONV_DLY = DEF_CONV_DLY,
  parameter int SYNC     = DEF_SYNC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            start_n,
  input  logic            io_clk,
  input  logic            sdi,
  input  logic            cmp_in,
  output logic            sdo,
  output logic            sample_en,
  output logic [CH_W-1:0] hold_ch,
  output logic            eoc
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0]  s_q, s_p;
  logic              cs_high, cs_fall, cs_rise;
  logic              start_fall, start_rise;
  logic              io_rise, io_fall;
  logic [ADDR_W-1:0] addr;
  logic              addr_done, samp_end;
  logic [RES_W-1:0]  result;
  logic              frame_ro, async_flag, conv_busy;

  adc_seq_sync #(.W(NSYNC), .STAGES(SYNC), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, start_n, io_clk, sdi}),
    .q(s_q), .q_prev(s_p)
  );

  assign cs_high    = s_q[3];
  assign cs_fall    = s_p[3] && !s_q[3];
  assign cs_rise    = !s_p[3] && s_q[3];
  assign start_fall = s_p[2] && !s_q[2];
  assign start_rise = !s_p[2] && s_q[2];
  assign io_rise    = !s_p[1] && s_q[1];
  assign io_fall    = s_p[1] && !s_q[1];

  adc_seq_frame #(.RES_W(RES_W), .ADDR_W(ADDR_W), .SAMP_IO(SAMP_IO)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_low(!cs_high),
    .io_rise(io_rise), .io_fall(io_fall), .sdi_s(s_q[0]), .load_val(result),
    .sdo(sdo), .addr(addr), .addr_done(addr_done), .samp_end(samp_end)
  );

  adc_seq_core #(.RES_W(RES_W), .CH_W(CH_W), .CONV_DLY(CONV_DLY)) u_core (
    .clk(clk), .rst_n(rst_n), .start_fall(start_fall), .start_rise(start_rise),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_high(cs_high),
    .addr_done(addr_done), .addr_ch(addr[CH_W-1:0]), .samp_end(samp_end),
    .cmp_in(cmp_in), .sample_en(sample_en), .hold_ch(hold_ch), .eoc(eoc),
    .result(result), .frame_ro(frame_ro), .async_flag(async_flag),
    .conv_busy(conv_busy)
  );
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sample_en,
  input logic            eoc,
  input logic [CH_W-1:0] hold_ch,
  input logic            start_fall,
  input logic            start_rise,
  input logic            cs_rise,
  input logic            cs_high,
  input logic            addr_done,
  input logic            frame_ro,
  input logic            async_flag,
  input logic            conv_busy
);
  AST_DISCARD_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    start_fall && cs_high |=> sample_en && !eoc);  // R2
  AST_NO_EOC_WHILE_SAMPLING: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> !eoc);  // R6
  AST_CONV_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_en) && !$past(cs_rise) |-> ##2 conv_busy);  // R3
  AST_EOC_FROM_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> $past(conv_busy) || $past(sample_en));  // R3
  AST_HOLD_CH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && $past(sample_en) |-> $stable(hold_ch));  // R7
  AST_READ_ONLY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ro && addr_done && !sample_en |=> !sample_en);  // R5
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && !start_rise |=> !async_flag);  // R8
  AST_CS_LOW_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    start_fall && !cs_high && !sample_en && !addr_done |=> !sample_en);  // R9
endmodule

bind adc_seq_ctrl adc_seq_checker #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .eoc(eoc), .hold_ch(hold_ch),
  .start_fall(start_fall), .start_rise(start_rise), .cs_rise(cs_rise),
  .cs_high(cs_high), .addr_done(addr_done), .frame_ro(frame_ro),
  .async_flag(async_flag), .conv_busy(conv_busy)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, start_n = 1'b1, io_clk = 1'b0, sdi = 1'b0, cmp_in = 1'b0;
  logic sdo, sample_en, eoc;
  logic [2:0] hold_ch;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .start_n(start_n), .io_clk(io_clk),
    .sdi(sdi), .cmp_in(cmp_in), .sdo(sdo), .sample_en(sample_en),
    .hold_ch(hold_ch), .eoc(eoc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Waits for the hold, feeds the comparator bits MSB first, checks eoc timing.
  task automatic conv_run(input logic [9:0] pat, input string req);
    int first;
    first = -1;
    @(negedge sample_en);
    for (int m = 1; m <= 14; m++) begin
      @(posedge clk);
      #1;
      if (eoc && first < 0) first = m;
      if (m >= 2 && m <= 11) cmp_in = pat[11-m];
    end
    chk(first == 12, req, first, 12);
  endtask

  task automatic frame_body(input logic [3:0] addr, input logic [9:0] exp_rd,
                            input bit ro);
    cs_n = 1'b0;
    wait_n(10);
    for (int k = 0; k < 10; k++) begin
      sdi = (k < 4) ? addr[3-k] : 1'b0;
      wait_n(10);
      chk(sdo == exp_rd[9-k], "R4 sdo bit", sdo, exp_rd[9-k]);
      io_clk = 1'b1;
      wait_n(10);
      if (k == 2) chk(!sample_en, "R6 no sampling before address", sample_en, 0);
      if (k == 4) begin
        if (ro) begin
          chk(!sample_en && eoc, "R5 read-only frame idle", {sample_en, eoc}, 2'b01);
        end else begin
          chk(sample_en && !eoc, "R6 frame sampling", {sample_en, eoc}, 2'b10);
          chk(hold_ch == addr[2:0], "R7 frame channel", hold_ch, addr[2:0]);
        end
      end
      if (k == 8) chk(sample_en == !ro, "R6 sampling window", sample_en, !ro);
      if (k == 9) chk(!sample_en, "R6 sampling ended", sample_en, 0);
      io_clk = 1'b0;
    end
    wait_n(10);
    if (ro) chk(eoc, "R5 no conversion", eoc, 1);
    cs_n = 1'b1;
    wait_n(10);
  endtask

  task automatic do_frame(input logic [3:0] addr, input logic [9:0] exp_rd,
                          input bit ro, input logic [9:0] pat);
    fork
      frame_body(addr, exp_rd, ro);
      begin
        if (!ro) conv_run(pat, "R6 frame conversion timing");
      end
    join
  endtask

  task automatic ext_sample(input logic [2:0] exp_ch, input logic [9:0] pat);
    @(negedge clk);
    start_n = 1'b0;
    wait_n(2);
    chk(!sample_en, "R10 not yet sampling", sample_en, 0);
    wait_n(1);
    chk(sample_en, "R10 sampling after sync", sample_en, 1);
    chk(hold_ch == exp_ch, "R2 preset channel", hold_ch, exp_ch);
    chk(!eoc, "R2 result discarded", eoc, 0);
    wait_n(30);
    chk(sample_en, "R2 sampling while strobe low", sample_en, 1);
    fork
      start_n = 1'b1;
      conv_run(pat, "R3 hold to eoc");
    join
    wait_n(5);
  endtask

  task automatic test_reset();
    chk(!sample_en && eoc && !sdo && hold_ch == 3'd0, "R1 reset state",
        {sample_en, eoc, sdo, hold_ch}, 6'b010000);
  endtask

  task automatic test_cs_low_strobe();
    cs_n = 1'b0;
    wait_n(10);
    start_n = 1'b0;
    wait_n(10);
    chk(!sample_en && eoc, "R9 strobe fall ignored", {sample_en, eoc}, 2'b01);
    start_n = 1'b1;
    wait_n(10);
    chk(!sample_en && eoc, "R9 strobe rise ignored", {sample_en, eoc}, 2'b01);
    cs_n = 1'b1;
    wait_n(10);
    // Flag not set: next frame samples (R9).
    do_frame(4'b0010, 10'h0F0, 1'b0, 10'h155);
    chk(hold_ch == 3'd2, "R9 frame after ignored strobe", hold_ch, 2);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
    test_reset();
    ext_sample(3'd0, 10'h2A5);
    do_frame(4'b0101, 10'h2A5, 1'b1, 10'h000);   // R5 read-only frame
    ext_sample(3'd5, 10'h13C);                   // R7 preset from read-only frame
    do_frame(4'b1011, 10'h13C, 1'b1, 10'h000);   // R8 first frame read-only
    do_frame(4'b0110, 10'h13C, 1'b0, 10'h3C1);   // R8 second frame samples
    do_frame(4'b1000, 10'h3C1, 1'b0, 10'h0F0);   // R7 bit 3 ignored
    test_cs_low_strobe();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule